// File: doc/BRIEF.md
# FIFO Watermark Data-Request Generator

This block sits beside the byte FIFO of an I2C master and decides, on every clock edge, whether the master should ask its host for service. On a receive transfer the host is asked to drain bytes once the FIFO has filled to a programmable high mark. It is also asked when no bytes remain to be fetched from the bus. On a transmit transfer the host is asked to supply bytes when the FIFO has room for everything still owed, or when the fill has dropped to a programmable low mark. While no bytes remain to be written, no request is raised.

The block also reports command completion. Completion holds whenever both residual counters, the bus side and the host side, have reached zero. When the bus is not busy, every output keeps its last value. The request is therefore a sticky status that only an active transfer can change. All four outputs are registered, so they reflect the inputs sampled at the previous clock edge.

Top module: `fifo_dreq_gen`

## Requirements
- R1: After reset, the high-water flag, the low-water flag and the data request are 0, and command-complete is 1.
- R2: While `bus_busy` is 0, all four outputs keep their values regardless of the other inputs.
- R3: During a busy receive (`rd_dir`=1), the high-water flag becomes 1 if `fill_cnt` >= `hi_mark`, else 0. The low-water flag is left unchanged.
- R4: During a busy receive, the data request is 1 when (the new high-water flag is 1 and `fill_cnt` is nonzero) or `fe_left` is zero, otherwise 0, subject to R7.
- R5: During a busy transmit (`rd_dir`=0), the low-water flag becomes 1 if `fill_cnt` <= `lo_mark`, else 0. The high-water flag is left unchanged.
- R6: During a busy transmit, the data request is 1 when `be_left` is nonzero and either (DEPTH - `fill_cnt`) >= `be_left` or the new low-water flag is 1, otherwise 0.
- R7: During a busy cycle with `fe_left` and `be_left` both zero, the data request is 0 and command-complete is 1.
- R8: During a busy cycle with either residual nonzero, command-complete is 0.
- R9: Outputs change only at a clock edge, one cycle after the inputs that cause the change are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_busy | input | 1 | A transfer owns the bus; enables evaluation |
| rd_dir | input | 1 | 1 = receive from bus, 0 = transmit to bus |
| fill_cnt | input | CNT_W (4) | Current FIFO entry count, 0..DEPTH |
| hi_mark | input | MARK_W (4) | High watermark for receive |
| lo_mark | input | MARK_W (4) | Low watermark for transmit |
| fe_left | input | RES_W (16) | Bytes still to move on the bus side |
| be_left | input | RES_W (16) | Bytes still to move on the host side |
| high_water | output | 1 | Fill at or above the high mark (receive) |
| low_water | output | 1 | Fill at or below the low mark (transmit) |
| data_req | output | 1 | Request for host service |
| cmd_done | output | 1 | Both residuals exhausted |

## Verification
The assertions assume that `fill_cnt` never exceeds DEPTH and that the inputs change only between clock edges. Under those conditions the free-space term stays non-negative and every property compares values from the same sampled cycle. The stimulus is driven on the falling edge and holds counts in the range 0..8. It exercises both directions at their boundaries: a zero count with a zero high mark, free space exactly equal to the residual, and a full FIFO against the low mark. It also covers the double-zero residual case and idle stretches in which the other inputs vary freely.

// File: rtl/fifo_dreq_gen.sv
module fifo_dreq_gen #(
  parameter int DEPTH  = 8,
  parameter int MARK_W = 4,
  parameter int RES_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic              rd_dir,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic [MARK_W-1:0] hi_mark,
  input  logic [MARK_W-1:0] lo_mark,
  input  logic [RES_W-1:0]  fe_left,
  input  logic [RES_W-1:0]  be_left,
  output logic              high_water,
  output logic              low_water,
  output logic              data_req,
  output logic              cmd_done
);

  localparam int CW = (CNT_W > MARK_W) ? CNT_W : MARK_W;

  logic [CW-1:0]    cnt_x, hi_x, lo_x;
  logic [RES_W-1:0] free_sp;
  logic             fe_zero, be_zero, both_zero;
  logic             hw_n, lw_n, dr_n, done_n;

  assign cnt_x     = CW'(fill_cnt);
  assign hi_x      = CW'(hi_mark);
  assign lo_x      = CW'(lo_mark);
  assign free_sp   = RES_W'(DEPTH) - RES_W'(fill_cnt);
  assign fe_zero   = (fe_left == '0);
  assign be_zero   = (be_left == '0);
  assign both_zero = fe_zero && be_zero;

  always_comb begin
    hw_n   = high_water;
    lw_n   = low_water;
    dr_n   = data_req;
    done_n = cmd_done;
    if (bus_busy) begin
      if (rd_dir) begin
        hw_n = (cnt_x >= hi_x);
        dr_n = (hw_n && (fill_cnt != '0)) || fe_zero;
      end else begin
        lw_n = (cnt_x <= lo_x);
        dr_n = !be_zero && ((free_sp >= be_left) || lw_n);
      end
      if (both_zero) begin
        dr_n   = 1'b0;
        done_n = 1'b1;
      end else begin
        done_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_water <= 1'b0;
      low_water  <= 1'b0;
      data_req   <= 1'b0;
      cmd_done   <= 1'b1;
    end else begin
      high_water <= hw_n;
      low_water  <= lw_n;
      data_req   <= dr_n;
      cmd_done   <= done_n;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> $stable({high_water, low_water, data_req, cmd_done}));

  // R7
  both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && fe_left == '0 && be_left == '0) |=> (cmd_done && !data_req));

  // R8
  not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && (fe_left != '0 || be_left != '0)) |=> !cmd_done);

  // R4
  rd_fe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && rd_dir && fe_left == '0 && be_left != '0) |=> data_req);

  // R6
  wr_be_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !rd_dir && be_left == '0) |=> !data_req);

  // R3
  rd_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && rd_dir) |=> $stable(low_water));

  // R5
  wr_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !rd_dir) |=> $stable(high_water));

endmodule

// File: tb/fifo_dreq_gen_tb.sv
module fifo_dreq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_busy = 1'b0, rd_dir = 1'b0;
  logic [3:0]  fill_cnt = '0, hi_mark = '0, lo_mark = '0;
  logic [15:0] fe_left = '0, be_left = '0;
  logic        high_water, low_water, data_req, cmd_done;

  int checks = 0;
  int errors = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic m_hw = 0, m_lw = 0, m_dr = 0, m_done = 1;

  always #10 clk = ~clk;

  fifo_dreq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .rd_dir(rd_dir),
    .fill_cnt(fill_cnt), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .fe_left(fe_left), .be_left(be_left), .high_water(high_water),
    .low_water(low_water), .data_req(data_req), .cmd_done(cmd_done));

  task automatic compare(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hw,lw,dr,done} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic busy, input logic rd,
                       input int cnt, input int hi, input int lo,
                       input int fe, input int be);
    @(negedge clk);
    bus_busy = busy; rd_dir = rd; fill_cnt = 4'(cnt);
    hi_mark = 4'(hi); lo_mark = 4'(lo); fe_left = 16'(fe); be_left = 16'(be);
    #1 compare("R9 no change before edge",
               {high_water, low_water, data_req, cmd_done},
               {m_hw, m_lw, m_dr, m_done});
    if (busy) begin
      if (rd) begin
        m_hw = (cnt >= hi);
        m_dr = (m_hw && cnt != 0) || (fe == 0);
      end else begin
        m_lw = (cnt <= lo);
        m_dr = (be != 0) && (((8 - cnt) >= be) || m_lw);
      end
      if (fe == 0 && be == 0) begin
        m_dr = 0; m_done = 1;
      end else m_done = 0;
    end
    exp_q.push_back({m_hw, m_lw, m_dr, m_done});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compare(t, {high_water, low_water, data_req, cmd_done}, e);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 compare("R1 reset values", {high_water, low_water, data_req, cmd_done}, 4'b0001);
    @(negedge clk) rst_n = 1'b1;
    drive("R2 idle ignores inputs", 0, 1, 8, 0, 9, 0, 5);
    drive("R2 idle ignores inputs", 0, 0, 0, 3, 15, 0, 0);
    drive("R3 R4 read above high mark", 1, 1, 5, 4, 0, 3, 3);
    drive("R4 read below high mark", 1, 1, 2, 4, 15, 3, 3);
    drive("R4 read front residual zero", 1, 1, 0, 4, 15, 0, 2);
    drive("R3 R4 read zero count zero mark", 1, 1, 0, 0, 15, 2, 2);
    drive("R5 R6 write at low mark, hw held", 1, 0, 3, 0, 3, 4, 2);
    drive("R6 write short of free space", 1, 0, 7, 0, 2, 6, 5);
    drive("R6 write free equals residual", 1, 0, 7, 0, 2, 6, 1);
    drive("R6 write full but low-water", 1, 0, 8, 0, 8, 4, 3);
    drive("R6 R8 write back residual zero", 1, 0, 4, 0, 2, 3, 0);
    drive("R7 write both residuals zero", 1, 0, 0, 0, 2, 0, 0);
    drive("R7 read both zero, high-water", 1, 1, 8, 1, 0, 0, 0);
    drive("R2 idle holds after completion", 0, 0, 2, 9, 0, 7, 7);
    drive("R8 read residual resumes", 1, 1, 1, 3, 0, 1, 1);
    drive("R2 idle holds request", 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule